// File: doc/BRIEF.md
# Weight-Stationary Systolic Multiply-Accumulate Array

This block is a square grid of multiply-accumulate cells that multiplies a stored weight tile by a stream of input vectors. The grid is `DIM` by `DIM`, with a default of 8. Before any computation starts, a load port shifts the weight tile into the grid from the top, one row per cycle. Each cell keeps its weight until the next load. When a complete row of weights has been written in on every cycle, no other control is needed.

Input vectors arrive one per cycle. Element k of a vector is delayed by k cycles and then enters row k at the left edge. From there it moves one cell to the right on every cycle. Each cell multiplies the signed 8-bit input it receives by its signed 8-bit weight. It adds the product to the signed 32-bit partial sum arriving from the cell above and passes the new sum downward. The top row starts from zero.

At the bottom edge, column j is delayed by `DIM-1-j` extra cycles. This makes every column of one vector's result appear in the same cycle, qualified by a valid flag that travels alongside the data. Larger matrices are handled by a controller outside this block, which splits them into tiles and streams each tile through.

Top module: `ws_systolic_array`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_vec` is all zeros. Every stored weight is zero, so a vector sent before any load yields an all-zero result.
- R2: For an accepted vector x, result column j equals the int32 sum over k of x[k]*W[k][j]. All operands are two's-complement 8-bit. The extreme case where every operand is -128 gives 131072 per column.
- R3: On each cycle with `load_en` high, every weight row moves down one row and `load_row` is written into row 0. After `DIM` consecutive load cycles, the row presented on load cycle n (counting from 0) sits in row `DIM-1-n`. While `load_en` is low, no stored weight changes.
- R4: A vector presented with `in_valid` high while `load_en` is also high is dropped and produces no output.
- R5: A vector sampled at a rising edge appears on `out_vec`, with `out_valid` high, right after the (2*DIM-1)-th rising edge counted from and including the sampling edge. All `DIM` columns of that vector appear in that same cycle.
- R6: A new vector can be accepted on every cycle. Back-to-back vectors produce results on consecutive cycles, in the order they were accepted.
- R7: Field positions are as follows. Element k of `in_vec` is at bits [8k+7:8k] and feeds row k. Element j of `load_row` is at bits [8j+7:8j] and feeds column j. Result column j is at bits [32j+31:32j] of `out_vec`.
- R8: Idle cycles between accepted vectors reappear as the same gaps in `out_valid`.
- R9: A second full load replaces every weight. Vectors accepted after it use only the new weights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Shift `load_row` into weight row 0 this cycle |
| load_row | input | DIM*8 | One row of signed 8-bit weights |
| in_valid | input | 1 | `in_vec` holds a vector to process |
| in_vec | input | DIM*8 | Signed 8-bit input vector, element k feeds row k |
| out_valid | output | 1 | `out_vec` holds a finished result row |
| out_vec | output | DIM*32 | Signed 32-bit results, one per column |

## Verification
The corner cases the bench targets are listed below, with the failure each one exposes:
- **All operands at -128.** A cell that treats operands as unsigned, or that truncates the product before extending it, gives the wrong magnitude or sign.
- **Unit input vectors.** These read back individual weight rows. A load order that is reversed, or weight columns that are swapped, shows up at once.
- **Vectors sent during a load.** These must vanish. A design that accepts them emits spurious results.
- **Bubbles and back-to-back streams.** Every result's arrival cycle is timed against the fixed fill latency. A mismatched skew or deskew delay spreads one vector's columns over different cycles, so the results are wrong or land in the wrong cycle.

// File: rtl/ws_array_pkg.sv
package ws_array_pkg;

    // Operand and accumulator widths shared by every cell of the array.
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ACC_W  = 32;
    localparam int unsigned PROD_W = 2 * DATA_W;

    // Registered state of one processing cell.
    typedef struct packed {
        logic [DATA_W-1:0] w;     // stationary weight
        logic [DATA_W-1:0] a;     // input value travelling right
        logic [ACC_W-1:0]  psum;  // partial sum travelling down
    } pe_state_t;

endpackage

// File: rtl/ws_delay_line.sv
// Fixed-length register pipeline; DEPTH 0 is a plain wire.
module ws_delay_line #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_pipe
            logic [WIDTH-1:0] pipe_d [DEPTH];
            logic [WIDTH-1:0] pipe_q [DEPTH];

            always_comb begin
                pipe_d[0] = din;
                for (int s = 1; s < int'(DEPTH); s++) begin
                    pipe_d[s] = pipe_q[s-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int s = 0; s < int'(DEPTH); s++) begin
                        pipe_q[s] <= '0;
                    end
                end else begin
                    pipe_q <= pipe_d;
                end
            end

            assign dout = pipe_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/ws_pe.sv
// One multiply-accumulate cell: holds a weight, forwards input right and sum down.
module ws_pe
    import ws_array_pkg::*;
#(
    parameter int unsigned ROW = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] w_in,
    output logic [DATA_W-1:0] w_out,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    input  logic [ACC_W-1:0]  psum_in,
    output logic [ACC_W-1:0]  psum_out
);

    // Largest magnitude a partial sum can reach after ROW+1 products.
    localparam longint PSUM_BOUND = longint'(ROW + 1) << (PROD_W - 2);

    pe_state_t               st_d, st_q;
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        st_d      = st_q;
        prod      = $signed(a_in) * $signed(st_q.w);
        if (load_en) begin
            st_d.w = w_in;
        end
        st_d.a    = a_in;
        st_d.psum = ACC_W'($signed(psum_in) + ACC_W'(prod));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign w_out    = st_q.w;
    assign a_out    = st_q.a;
    assign psum_out = st_q.psum;

    // R3: a weight is frozen whenever no load is in progress
    assert_weight_hold_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(st_q.w)
    );

    // R2: signed accumulation never leaves the range ROW+1 products can reach
    assert_psum_bound_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (longint'($signed(st_q.psum)) <= PSUM_BOUND) &&
        (longint'($signed(st_q.psum)) >= -PSUM_BOUND)
    );

endmodule

// File: rtl/ws_systolic_array.sv
// DIM x DIM weight-stationary grid with input skew and output deskew.
module ws_systolic_array
    import ws_array_pkg::*;
#(
    parameter int unsigned DIM = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_en,
    input  logic [DIM*DATA_W-1:0]   load_row,
    input  logic                    in_valid,
    input  logic [DIM*DATA_W-1:0]   in_vec,
    output logic                    out_valid,
    output logic [DIM*ACC_W-1:0]    out_vec
);

    localparam int unsigned LATENCY = 2 * DIM - 1;
    localparam int unsigned CNT_W   = $clog2(LATENCY + 1) + 1;

    logic [DATA_W-1:0] a_bus    [DIM][DIM+1];
    logic [DATA_W-1:0] w_bus    [DIM+1][DIM];
    logic [ACC_W-1:0]  psum_bus [DIM+1][DIM];
    logic              accept;

    assign accept = in_valid & ~load_en;

    // Left edge: element k waits k cycles before entering row k.
    // Top edge: weight rows enter here, sums start at zero.
    generate
        for (genvar k = 0; k < DIM; k++) begin : g_skew
            ws_delay_line #(.WIDTH(DATA_W), .DEPTH(k)) u_skew (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (in_vec[k*DATA_W +: DATA_W]),
                .dout (a_bus[k][0])
            );
        end
        for (genvar j = 0; j < DIM; j++) begin : g_top
            assign w_bus[0][j]    = load_row[j*DATA_W +: DATA_W];
            assign psum_bus[0][j] = '0;
        end
    endgenerate

    // The cell grid.
    generate
        for (genvar i = 0; i < DIM; i++) begin : g_row
            for (genvar j = 0; j < DIM; j++) begin : g_col
                ws_pe #(.ROW(i)) u_pe (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .load_en (load_en),
                    .w_in    (w_bus[i][j]),
                    .w_out   (w_bus[i+1][j]),
                    .a_in    (a_bus[i][j]),
                    .a_out   (a_bus[i][j+1]),
                    .psum_in (psum_bus[i][j]),
                    .psum_out(psum_bus[i+1][j])
                );
            end
        end
    endgenerate

    // Bottom edge: column j waits DIM-1-j cycles so one vector's results align.
    generate
        for (genvar j = 0; j < DIM; j++) begin : g_deskew
            ws_delay_line #(.WIDTH(ACC_W), .DEPTH(DIM - 1 - j)) u_deskew (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (psum_bus[DIM][j]),
                .dout (out_vec[j*ACC_W +: ACC_W])
            );
        end
    endgenerate

    // Valid flag travels the full fill latency beside the data.
    ws_delay_line #(.WIDTH(1), .DEPTH(LATENCY)) u_valid (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (accept),
        .dout (out_valid)
    );

    // Values leaving the right and bottom edges go nowhere.
    logic unused_edge;
    always_comb begin
        unused_edge = 1'b0;
        for (int r = 0; r < int'(DIM); r++) begin
            unused_edge = unused_edge ^ (^a_bus[r][DIM]) ^ (^w_bus[DIM][r]);
        end
    end

    // Count of vectors accepted whose results have not left yet.
    logic [CNT_W-1:0] inflight_d, inflight_q;

    always_comb begin
        inflight_d = inflight_q;
        if (accept && !out_valid) begin
            inflight_d = inflight_q + 1'b1;
        end else if (!accept && out_valid) begin
            inflight_d = inflight_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inflight_q <= '0;
        end else begin
            inflight_q <= inflight_d;
        end
    end

    // R4: every result row traces back to an accepted vector
    assert_valid_has_source_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight_q != '0)
    );

    // R6: with one vector per cycle, at most LATENCY are ever in flight
    assert_inflight_bound_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        inflight_q <= CNT_W'(LATENCY)
    );

    // R1: nothing is reported valid straight out of reset
    assert_quiet_after_reset_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid
    );

    // R5: an accepted vector is counted in flight on the following cycle
    assert_accept_counted_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        accept |=> (inflight_q != '0)
    );

endmodule

// File: tb/ws_systolic_array_tb.sv
module ws_systolic_array_tb;

    localparam int DIM   = 8;
    localparam int DW    = 8;
    localparam int AW    = 32;
    localparam int CLK_P = 10;
    localparam int LAT   = 2 * DIM - 1;

    // Stimulus table: element k at bits [8k+7:8k].
    localparam logic [DIM*DW-1:0] VEC_TAB [7] = '{
        64'h8080_8080_8080_8080,   // all -128
        64'h7f7f_7f7f_7f7f_7f7f,   // all +127
        64'h0000_0000_0000_0000,
        64'h0807_0605_0403_0201,
        64'h807f_807f_807f_807f,
        64'hff01_ff01_ff01_ff01,
        64'h00ff_0080_7f00_01fe
    };

    logic                 clk, rst_n, load_en, in_valid, out_valid;
    logic [DIM*DW-1:0]    load_row, in_vec;
    logic [DIM*AW-1:0]    out_vec;

    ws_systolic_array #(.DIM(DIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_row(load_row),
        .in_valid(in_valid), .in_vec(in_vec),
        .out_valid(out_valid), .out_vec(out_vec)
    );

    int w [DIM][DIM];
    logic [DIM*AW-1:0] exp_q [$];
    int iss_q [$];
    string tag = "R1";
    int cyc = 0, checks = 0, errors = 0, n_sent = 0, n_out = 0;

    initial clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    function automatic logic [DIM*AW-1:0] ref_mul(input logic [DIM*DW-1:0] v);
        logic [DIM*AW-1:0] r;
        for (int j = 0; j < DIM; j++) begin
            int s = 0;
            for (int k = 0; k < DIM; k++) begin
                s += int'($signed(v[k*DW +: DW])) * w[k][j];
            end
            r[j*AW +: AW] = s;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [DIM*AW-1:0] act, input logic [DIM*AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Output monitor: data and arrival cycle of every result row.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_out++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4", "unexpected result row", out_vec, '0);
            end else begin
                logic [DIM*AW-1:0] e;
                int issued;
                e      = exp_q.pop_front();
                issued = iss_q.pop_front();
                chk(out_vec == e, tag, "result row", out_vec, e);
                chk(cyc - issued == LAT, "R5", "arrival latency",
                    (DIM*AW)'(cyc - issued), (DIM*AW)'(LAT));
            end
        end
    end

    task automatic step(input bit vld, input logic [DIM*DW-1:0] vec,
                        input bit ld, input logic [DIM*DW-1:0] row);
        @(negedge clk);
        in_valid = vld;
        in_vec   = vec;
        load_en  = ld;
        load_row = row;
        if (vld && !ld) begin
            exp_q.push_back(ref_mul(vec));
            iss_q.push_back(cyc);
            n_sent++;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) step(1'b0, '0, 1'b0, '0);
    endtask

    // R3 order: row DIM-1 goes in first, row 0 last.
    task automatic load_weights(input bit hold_valid);
        for (int n = 0; n < DIM; n++) begin
            logic [DIM*DW-1:0] row;
            for (int j = 0; j < DIM; j++) begin
                row[j*DW +: DW] = DW'(w[DIM-1-n][j]);
            end
            step(hold_valid, 64'(hold_valid ? {$urandom, $urandom} : 0), 1'b1, row);
        end
    endtask

    initial begin
        rst_n = 1'b0; load_en = 1'b0; in_valid = 1'b0;
        load_row = '0; in_vec = '0;
        for (int i = 0; i < DIM; i++)
            for (int j = 0; j < DIM; j++) w[i][j] = 0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", (DIM*AW)'(out_valid), '0);
        chk(out_vec == '0, "R1", "out_vec in reset", out_vec, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", (DIM*AW)'(out_valid), '0);

        // R1: weights start at zero, so any vector gives zeros
        tag = "R1";
        step(1'b1, VEC_TAB[3], 1'b0, '0);
        idle(LAT + 2);

        // R3: distinct weights, unit vectors read back individual rows
        for (int i = 0; i < DIM; i++)
            for (int j = 0; j < DIM; j++) w[i][j] = i * 8 + j - 20;
        load_weights(1'b0);
        tag = "R3";
        for (int k = 0; k < DIM; k++) step(1'b1, 64'(1) << (k*DW), 1'b0, '0);
        idle(LAT + 2);

        // R6: table streamed back to back
        tag = "R6";
        foreach (VEC_TAB[t]) step(1'b1, VEC_TAB[t], 1'b0, '0);
        idle(LAT + 2);

        // R8: bubbles of 0, 1 and 2 cycles between vectors
        tag = "R8";
        foreach (VEC_TAB[t]) begin
            step(1'b1, VEC_TAB[t], 1'b0, '0);
            idle(t % 3);
        end
        idle(LAT + 2);

        // R2: extreme signed operands
        for (int i = 0; i < DIM; i++)
            for (int j = 0; j < DIM; j++) w[i][j] = -128;
        load_weights(1'b0);
        tag = "R2";
        step(1'b1, VEC_TAB[0], 1'b0, '0);   // 8 * 16384 = 131072
        step(1'b1, VEC_TAB[1], 1'b0, '0);   // 8 * -16256
        step(1'b1, VEC_TAB[4], 1'b0, '0);
        idle(LAT + 2);

        // R4: vectors held valid through a reload must be dropped
        for (int i = 0; i < DIM; i++)
            for (int j = 0; j < DIM; j++) w[i][j] = int'($signed(DW'($urandom)));
        load_weights(1'b1);
        idle(LAT + 2);
        chk(n_out == n_sent, "R4", "result count after load with valid",
            (DIM*AW)'(n_out), (DIM*AW)'(n_sent));

        // R9 then R7: new weights used, random vectors back to back
        tag = "R9";
        for (int n = 0; n < 40; n++) begin
            if (n == 4) tag = "R7";
            step(1'b1, {$urandom, $urandom}, 1'b0, '0);
        end
        idle(LAT + 2);
        chk(exp_q.size() == 0, "R6", "results outstanding at end",
            (DIM*AW)'(exp_q.size()), '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule